// File: doc/BRIEF.md
# Pipelined Fixed-Coefficient FIR Filter

This block is a short finite-impulse-response filter with constant coefficients. It computes y(n) = b0·x(n) + b1·x(n-1) + b2·x(n-2) (+ b3·x(n-3) in the four-tap build), taking one signed sample per clock and returning one signed result per clock after a fixed number of cycles. Coefficients, widths and tap count are parameters, so each instance is a dedicated filter with no run-time programming.

Two structures are selectable. The transposed structure feeds the registered sample to every multiplier at once and folds the products into a chain of registered partial sums, so every register-to-register path holds at most one multiplier or one adder. The direct structure keeps a sample delay line and sums the products in a registered binary adder tree. Both give the same numbers; only the delay differs. A further option splits every multiplication into two registered half-products, trading one extra cycle for a shorter multiply path.

Sums are kept at full precision with two guard bits and truncated toward minus infinity to the output width. A companion valid flag follows the input valid flag through a matching delay.

Top module: `fir_pipe`

## Requirements
- R1: After the pipeline delay, `dout` equals (sum over k of b_k·x(n-k)) arithmetically shifted right by ACC_W-OUT_W, where tap k's two's-complement coefficient sits at `COEFS[k*COEF_W +: COEF_W]`; this holds for both three and four taps.
- R2: A cycle with `din_vld` low enters a zero sample into the filter, whatever `din` carries.
- R3: In the transposed structure without the split multiplier, the result for a sample captured at a rising edge appears on `dout` right after the third rising edge counted from and including that capture edge.
- R4: The direct structure gives the same values as the transposed one, with a delay of 1 + M + ceil(log2(NTAPS)) edges, where M is 1 (plain) or 2 (split multiplier).
- R5: The split-multiplier option adds exactly one cycle of delay to either structure and does not change any value.
- R6: `dout_vld` equals `din_vld` delayed by the same number of edges as the data.
- R7: A synchronous active-high `rst` clears every sample, product and partial-sum register, so `dout` is 0 and `dout_vld` is 0 after a reset edge, and later results treat pre-reset samples as zero.
- R8: Accumulation width is ACC_W = DATA_W + COEF_W + 2, so four taps of (-128)·(-128) give 65536, shown as 16384 on a 16-bit output without wrapping.
- R9: After NTAPS + latency - 1 consecutive zero samples, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| din_vld | input | 1 | Input sample qualifier; low enters a zero sample |
| din | input | DATA_W | Signed input sample |
| dout_vld | output | 1 | Delayed copy of `din_vld` aligned to `dout` |
| dout | output | OUT_W | Signed filtered result, truncated |

## Verification
A sample captured at rising edge e produces its result after edge e+2 in the plain transposed build, e+3 in the plain direct or split transposed builds, and e+4 in the split direct build, with the valid flag aligned to the same edge. The bench records every captured sample with its edge index and, at each falling edge, compares each instance against the sample whose capture edge lies exactly that many edges back, so an early or late result is reported as a mismatch. The vector table is checked at the edge two after each row's capture edge.

// File: rtl/fir_pkg.sv
package fir_pkg;

    // Structure selector for the summation network.
    typedef enum logic {
        FORM_DIRECT     = 1'b0,
        FORM_TRANSPOSED = 1'b1
    } fir_form_e;

    // Register stages inside one multiplier.
    function automatic int mult_stages(input bit fine);
        return fine ? 2 : 1;
    endfunction

    // Edges from capture of a sample to its result on the output.
    function automatic int fir_latency(input fir_form_e form, input bit fine, input int ntaps);
        if (form == FORM_TRANSPOSED)
            return mult_stages(fine) + 2;
        return 1 + mult_stages(fine) + $clog2(ntaps);
    endfunction

endpackage

// File: rtl/fir_mult.sv
module fir_mult #(
    parameter int               DATA_W = 8,
    parameter int               COEF_W = 8,
    parameter logic [COEF_W-1:0] COEF  = '0,
    parameter bit               FINE   = 1'b0
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic signed [DATA_W-1:0]        x,
    output logic signed [DATA_W+COEF_W-1:0] p
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam logic signed [COEF_W-1:0] C_S = COEF;

    if (FINE) begin : g_split
        localparam int LO_W = COEF_W / 2;
        localparam int HI_W = COEF_W - LO_W;
        localparam int PH_W = DATA_W + HI_W;
        localparam int PL_W = DATA_W + LO_W + 1;
        localparam logic signed [HI_W-1:0] C_HI = COEF[COEF_W-1 -: HI_W];
        localparam logic signed [LO_W:0]   C_LO = {1'b0, COEF[LO_W-1:0]};

        logic signed [PH_W-1:0] part_hi;
        logic signed [PL_W-1:0] part_lo;

        always_ff @(posedge clk) begin
            if (rst) begin
                part_hi <= '0;
                part_lo <= '0;
                p       <= '0;
            end else begin
                part_hi <= PH_W'(x) * PH_W'(C_HI);
                part_lo <= PL_W'(x) * PL_W'(C_LO);
                p       <= (PROD_W'(part_hi) <<< LO_W) + PROD_W'(part_lo);
            end
        end

        // Age since reset, saturating; guards the two-deep look-back.
        logic [1:0] age;
        always_ff @(posedge clk) begin
            if (rst)            age <= '0;
            else if (age != 2'd3) age <= age + 2'd1;
        end

        assert_split_product_R5: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd2) |-> (p == PROD_W'($past(x, 2)) * PROD_W'(C_S)));
    end else begin : g_plain
        always_ff @(posedge clk) begin
            if (rst) p <= '0;
            else     p <= PROD_W'(x) * PROD_W'(C_S);
        end

        assert_zero_product_R1: assert property (@(posedge clk) disable iff (rst)
            (x == '0) |=> (p == '0));
    end

endmodule

// File: rtl/fir_xchain.sv
module fir_xchain #(
    parameter int NTAPS  = 4,
    parameter int PROD_W = 16,
    parameter int ACC_W  = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [PROD_W-1:0] prod [NTAPS],
    output logic signed [ACC_W-1:0]  acc
);
    // z[k] holds sum of b_j*x for j >= k, each one edge older per step.
    logic signed [ACC_W-1:0] z [NTAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NTAPS; k++) z[k] <= '0;
        end else begin
            for (int k = 0; k < NTAPS - 1; k++)
                z[k] <= ACC_W'(prod[k]) + z[k+1];
            z[NTAPS-1] <= ACC_W'(prod[NTAPS-1]);
        end
    end

    assign acc = z[0];

endmodule

// File: rtl/fir_dtree.sv
module fir_dtree #(
    parameter int NTAPS  = 4,
    parameter int PROD_W = 16,
    parameter int ACC_W  = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [PROD_W-1:0] prod [NTAPS],
    output logic signed [ACC_W-1:0]  acc
);
    localparam int LVLS = $clog2(NTAPS);
    localparam int W    = 1 << LVLS;

    logic signed [ACC_W-1:0] leaf [W];
    logic signed [ACC_W-1:0] node [LVLS][W];

    always_comb begin
        for (int j = 0; j < NTAPS; j++) leaf[j] = ACC_W'(prod[j]);
        for (int j = NTAPS; j < W; j++) leaf[j] = '0;
    end

    // One adder per level, one register per level.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < LVLS; l++)
                for (int j = 0; j < W; j++) node[l][j] <= '0;
        end else begin
            for (int j = 0; j < W / 2; j++)
                node[0][j] <= leaf[2*j] + leaf[2*j+1];
            for (int l = 1; l < LVLS; l++)
                for (int j = 0; j < (W >> (l + 1)); j++)
                    node[l][j] <= node[l-1][2*j] + node[l-1][2*j+1];
        end
    end

    assign acc = node[LVLS-1][0];

endmodule

// File: rtl/fir_pipe.sv
module fir_pipe
    import fir_pkg::*;
#(
    parameter int                      DATA_W = 8,
    parameter int                      COEF_W = 8,
    parameter int                      NTAPS  = 4,
    parameter int                      OUT_W  = 16,
    parameter logic [NTAPS*COEF_W-1:0] COEFS  = 32'h8043_D317,
    parameter fir_form_e               FORM   = FORM_TRANSPOSED,
    parameter bit                      FINE   = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     din_vld,
    input  logic signed [DATA_W-1:0] din,
    output logic                     dout_vld,
    output logic signed [OUT_W-1:0]  dout
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = DATA_W + COEF_W + 2;
    localparam int SHIFT  = ACC_W - OUT_W;
    localparam int LAT    = fir_latency(FORM, FINE, NTAPS);
    localparam int SETTLE = LAT + NTAPS - 1;

    logic signed [DATA_W-1:0] x_in;
    logic signed [DATA_W-1:0] tap_x [NTAPS];
    logic signed [PROD_W-1:0] prod  [NTAPS];
    logic signed [ACC_W-1:0]  acc;
    logic [LAT-1:0]           vsr;

    // Input register: an unqualified cycle enters zero.
    always_ff @(posedge clk) begin
        if (rst) x_in <= '0;
        else     x_in <= din_vld ? din : '0;
    end

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        fir_mult #(
            .DATA_W(DATA_W),
            .COEF_W(COEF_W),
            .COEF  (COEFS[k*COEF_W +: COEF_W]),
            .FINE  (FINE)
        ) u_mult (
            .clk(clk),
            .rst(rst),
            .x  (tap_x[k]),
            .p  (prod[k])
        );
    end

    if (FORM == FORM_TRANSPOSED) begin : g_xpose
        always_comb begin
            for (int k = 0; k < NTAPS; k++) tap_x[k] = x_in;
        end

        fir_xchain #(.NTAPS(NTAPS), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_sum (
            .clk (clk),
            .rst (rst),
            .prod(prod),
            .acc (acc)
        );
    end else begin : g_direct
        logic signed [DATA_W-1:0] dly [NTAPS-1];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int j = 0; j < NTAPS - 1; j++) dly[j] <= '0;
            end else begin
                dly[0] <= x_in;
                for (int j = 1; j < NTAPS - 1; j++) dly[j] <= dly[j-1];
            end
        end

        always_comb begin
            tap_x[0] = x_in;
            for (int k = 1; k < NTAPS; k++) tap_x[k] = dly[k-1];
        end

        fir_dtree #(.NTAPS(NTAPS), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_sum (
            .clk (clk),
            .rst (rst),
            .prod(prod),
            .acc (acc)
        );
    end

    // Valid flag travels alongside the data.
    always_ff @(posedge clk) begin
        if (rst) vsr <= '0;
        else     vsr <= {vsr[LAT-2:0], din_vld};
    end

    assign dout_vld = vsr[LAT-1];
    assign dout     = OUT_W'(acc >>> SHIFT);

    // ---------------------------------------------------------------
    // Checking aids: edges since reset and run of zero samples.
    int unsigned since_rst;
    int unsigned zero_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 0;
            zero_run  <= 0;
        end else begin
            if (since_rst < LAT + 1) since_rst <= since_rst + 1;
            if (din_vld && din != '0) zero_run <= 0;
            else if (zero_run < SETTLE + 1) zero_run <= zero_run + 1;
        end
    end

    assert_vld_delay_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= LAT) |-> (dout_vld == $past(din_vld, LAT)));

    assert_reset_clear_R7: assert property (@(posedge clk)
        $past(rst) |-> (dout == '0 && !dout_vld));

    assert_zero_settle_R9: assert property (@(posedge clk) disable iff (rst)
        (zero_run >= SETTLE) |-> (dout == '0));

endmodule

// File: tb/fir_pipe_bench.sv
`timescale 1ns/1ps
module fir_pipe_bench;
    import fir_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din_vld = 1'b0;
    logic signed [7:0] din = '0;

    always #2.5 clk = ~clk;

    logic signed [15:0] y_a, y_d, y_f, y_df, y_3, y_x;
    logic v_a, v_d, v_f, v_df, v_3, v_x;

    fir_pipe u_fir_pipe (.clk(clk), .rst(rst), .din_vld(din_vld), .din(din),
                         .dout_vld(v_a), .dout(y_a));
    fir_pipe #(.FORM(FORM_DIRECT)) u_dir (.clk(clk), .rst(rst), .din_vld(din_vld),
                         .din(din), .dout_vld(v_d), .dout(y_d));
    fir_pipe #(.FINE(1'b1)) u_fine (.clk(clk), .rst(rst), .din_vld(din_vld),
                         .din(din), .dout_vld(v_f), .dout(y_f));
    fir_pipe #(.FORM(FORM_DIRECT), .FINE(1'b1)) u_dfine (.clk(clk), .rst(rst),
                         .din_vld(din_vld), .din(din), .dout_vld(v_df), .dout(y_df));
    fir_pipe #(.NTAPS(3), .COEFS(24'h43_D317)) u_tap3 (.clk(clk), .rst(rst),
                         .din_vld(din_vld), .din(din), .dout_vld(v_3), .dout(y_3));
    fir_pipe #(.COEFS(32'h8080_8080)) u_ext (.clk(clk), .rst(rst), .din_vld(din_vld),
                         .din(din), .dout_vld(v_x), .dout(y_x));

    int n_chk = 0;
    int n_err = 0;
    bit mon_on = 1'b0;

    int CF_MAIN [4] = '{23, -45, 67, -128};
    int CF_EXT  [4] = '{-128, -128, -128, -128};

    // Sample history since the last reset edge.
    int ent [4096];
    bit vh  [4096];
    int hcnt = 0;

    always @(posedge clk) begin
        if (rst) hcnt = 0;
        else begin
            ent[hcnt] = din_vld ? int'(din) : 0;
            vh[hcnt]  = din_vld;
            hcnt      = hcnt + 1;
        end
    end

    function automatic longint ref_y(input int i, input int nt, input int cf [4]);
        longint s = 0;
        for (int k = 0; k < nt; k++)
            if (i - k >= 0) s += longint'(cf[k]) * longint'(ent[i-k]);
        return s >>> 2;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_inst(input string tag, input longint y, input bit v,
                              input int lat, input int nt, input int cf [4]);
        int i = hcnt - lat;
        chk(tag, y, ref_y(i, nt, cf));
        chk({tag, " R6 valid"}, longint'(v), (i >= 0) ? longint'(vh[i]) : 0);
    endtask

    // Reference comparison for every instance at each falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            check_inst("R1 transposed", longint'(y_a), v_a, 3, 4, CF_MAIN);
            check_inst("R4 direct", longint'(y_d), v_d, 4, 4, CF_MAIN);
            check_inst("R5 transposed split", longint'(y_f), v_f, 4, 4, CF_MAIN);
            check_inst("R5 direct split", longint'(y_df), v_df, 5, 4, CF_MAIN);
            check_inst("R1 three-tap", longint'(y_3), v_3, 3, 3, CF_MAIN);
            check_inst("R8 extreme", longint'(y_x), v_x, 3, 4, CF_EXT);
        end
    end

    typedef struct packed {
        logic              vld;
        logic signed [7:0] x;
        logic signed [15:0] y;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b1,  8'sd4,    16'sd23},
        '{1'b1,  8'sd0,   -16'sd45},
        '{1'b1,  8'sd0,    16'sd67},
        '{1'b1,  8'sd0,  -16'sd128},
        '{1'b1,  8'sd0,     16'sd0},
        '{1'b1, -8'sd128, -16'sd736},
        '{1'b1, -8'sd128,  16'sd704},
        '{1'b1, -8'sd128, -16'sd1440},
        '{1'b1, -8'sd128,  16'sd2656},
        '{1'b1,  8'sd127,  16'sd4122},
        '{1'b1,  8'sd127,  16'sd1253},
        '{1'b1,  8'sd127,  16'sd5524},
        '{1'b1,  8'sd127, -16'sd2636},
        '{1'b0,  8'sd99,  -16'sd3366},
        '{1'b1,  8'sd1,   -16'sd1931},
        '{1'b1,  8'sd0,   -16'sd4076}
    };

    task automatic drive(input bit v, input logic signed [7:0] d);
        din_vld = v;
        din     = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        mon_on = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk("R7 reset dout", longint'(y_a), 0);
        chk("R7 reset valid", longint'(v_a), 0);
        rst = 1'b0;

        // Vector table: rows are captured one per edge; result due two edges later (R3).
        for (int i = 0; i < NV + 2; i++) begin
            if (i < NV) begin
                din_vld = TBL[i].vld;
                din     = TBL[i].x;
            end else begin
                din_vld = 1'b1;
                din     = '0;
            end
            @(posedge clk);
            @(negedge clk);
            if (i >= 2) begin
                chk((i - 2 == 13) ? "R2 invalid enters zero" : "R1 R3 R8 table",
                    longint'(y_a), longint'(TBL[i-2].y));
                chk("R6 table valid", longint'(v_a), longint'(TBL[i-2].vld));
            end
        end

        // R8: extreme operands on every tap.
        for (int i = 0; i < 6; i++) drive(1'b1, -8'sd128);
        chk("R8 extreme no wrap", longint'(y_x), 16384);

        // Random stream with gaps.
        for (int i = 0; i < 1200; i++) begin
            int r = int'($urandom_range(0, 15));
            logic signed [7:0] d;
            d = 8'($urandom);
            if (r == 0) d = -8'sd128;
            if (r == 1) d = 8'sd127;
            drive(r < 12, d);
        end

        // R2: unqualified garbage only enters zeros.
        for (int i = 0; i < 8; i++) drive(1'b0, -8'sd77);
        chk("R2 garbage ignored dout", longint'(y_a), 0);
        chk("R2 garbage ignored valid", longint'(v_a), 0);
        chk("R2 garbage ignored direct", longint'(y_d), 0);

        // R9: zeros settle the output.
        for (int i = 0; i < 3; i++) drive(1'b1, 8'sd50);
        for (int i = 0; i < 6; i++) drive(1'b1, 8'sd0);
        chk("R9 settle transposed", longint'(y_a), 0);
        chk("R9 settle three-tap", longint'(y_3), 0);
        chk("R9 settle valid", longint'(v_a), 1);

        // R7: reset mid-stream clears all state.
        for (int i = 0; i < 5; i++) drive(1'b1, 8'sd100);
        rst = 1'b1;
        drive(1'b1, 8'sd100);
        chk("R7 mid reset dout", longint'(y_a), 0);
        chk("R7 mid reset valid", longint'(v_a), 0);
        chk("R7 mid reset split", longint'(y_df), 0);
        drive(1'b1, 8'sd100);
        rst = 1'b0;
        drive(1'b1, 8'sd4);
        drive(1'b1, 8'sd0);
        drive(1'b1, 8'sd0);
        chk("R7 fresh impulse b0", longint'(y_a), 23);
        drive(1'b1, 8'sd0);
        chk("R7 fresh impulse b1", longint'(y_a), -45);
        for (int i = 0; i < 6; i++) drive(1'b0, 8'sd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule